// File: doc/BRIEF.md
# Smart Card Character Receiver

This block receives asynchronous characters from one shared open-drain I/O line, as used between a reader and a smart card. A character is a low start bit, eight data bits sent least significant bit first, and one parity bit. The nine data and parity bits together must hold an even number of ones. After the parity bit comes a slot in which the receiver can hold the line low to reject the character. The sender then repeats it.

Every bit lasts one elementary time unit (ETU), given in clock cycles on `etu_cycles`. The line passes through a synchronizer. A falling edge in idle starts a half-ETU wait. A low sample at that point confirms the start bit, and each later bit is sampled once, one ETU after the one before. If parity is correct, the byte goes to the data register and the data-full flag is raised. If parity is wrong, the parity-error flag is raised and the error signal is driven for one ETU, starting one ETU after the parity sample. The bad byte is still written to the data register, but the data-full flag is not set. The receive interrupt can serve as a DMA request, and a DMA or software read acknowledges it with `rd_ack`.

Frame FSM states:
- `ST_IDLE`: waits for a low line. The low line leads to `ST_START`.
- `ST_START`: samples at half an ETU. A high sample leads back to `ST_IDLE` and a low sample leads to `ST_DATA`.
- `ST_DATA`: eight samples, one ETU apart. The last one leads to `ST_PARITY`.
- `ST_PARITY`: the parity sample and frame completion lead to `ST_GUARD`.
- `ST_GUARD`: waits one ETU. A bad frame then leads to `ST_ERRSIG` and a good frame to `ST_IDLE`.
- `ST_ERRSIG`: pulls the line low for one ETU, then leads to `ST_IDLE`.

Top module: `sc_char_rx`

## Requirements
- R1: After reset, `rx_full`, `par_err`, `overrun`, `rx_irq`, `err_irq` and `line_pull_low` are all 0.
- R2: A frame with correct even parity puts its byte in `rd_data` (the first data bit becomes bit 0). It sets `rx_full` when `rx_full` was 0, and it leaves `par_err` unchanged.
- R3: A frame with wrong parity sets `par_err`. It does not set `rx_full`, and it drives `line_pull_low` for exactly `etu_cycles` cycles in the slot after the parity bit.
- R4: A frame with correct parity never drives `line_pull_low`.
- R5: A frame with wrong parity that completes while `rx_full` is 0 still writes its byte into `rd_data`. If `rx_full` is 1, `rd_data` keeps its value.
- R6: A frame with correct parity that completes while `rx_full` is 1 sets `overrun` and leaves `rd_data` and `rx_full` unchanged.
- R7: A one-cycle `rd_ack` clears `rx_full`. `perr_clr` clears `par_err` and `ovr_clr` clears `overrun`. A new error event at the same edge wins over its clear.
- R8: `rx_irq` equals `irq_en AND rx_full`. `err_irq` equals `irq_en AND (par_err OR overrun)`.
- R9: A low pulse on the line that ends before the half-ETU start sample is ignored. No flag, no data and no error signal result from it.
- R10: Sampling follows `etu_cycles`, and any value from 8 upward receives correctly. The value may change between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| etu_cycles | input | DIV_W | Clock cycles per elementary time unit (8 or more) |
| line_in | input | 1 | Level seen on the shared I/O line |
| line_pull_low | output | 1 | 1 pulls the open-drain line low (error signal) |
| irq_en | input | 1 | Interrupt enable for both requests |
| rd_ack | input | 1 | Data register read by DMA or software; clears data-full |
| perr_clr | input | 1 | Clears the parity-error flag |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | DATA_W | Receive data register |
| rx_full | output | 1 | Receive data full flag |
| par_err | output | 1 | Parity error flag |
| overrun | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt / DMA request |
| err_irq | output | 1 | Error interrupt request |

## Verification
The hardest case to reach is a character arriving while an earlier one is still unacknowledged, crossed with the parity outcome. A bad frame over full data must leave the stored byte alone, and a good one must raise overrun. The random sequence chooses independently, after every frame, whether to acknowledge, whether to clear each flag and whether the next frame carries a parity flip. This builds long runs of unread data with mixed good and bad characters. Directed cases add a short start glitch and a change of ETU length partway through the run. The bench wires the line as a wired-AND with `line_pull_low`, so the error pulse is measured on the line itself, and the glitch left on the line after the pulse must not start a false frame.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_GUARD,
        ST_ERRSIG
    } rx_state_e;
endpackage

// File: rtl/sc_rx_etu_timer.sv
module sc_rx_etu_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = (cnt_q == '0);
endmodule

// File: rtl/sc_rx_frame_fsm.sv
module sc_rx_frame_fsm
    import sc_rx_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_s,
    input  logic [DIV_W-1:0]  etu_cycles,
    input  logic              tick,
    output logic              tmr_load,
    output logic [DIV_W-1:0]  tmr_val,
    output logic              frame_done,
    output logic              frame_ok,
    output logic [DATA_W-1:0] frame_byte,
    output logic              pull_low
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    rx_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              bad_q;
    logic [DIV_W-1:0]  full_m1;
    logic [DIV_W-1:0]  half_m1;

    assign full_m1 = etu_cycles - 1'b1;
    assign half_m1 = (etu_cycles >> 1) - 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!line_s) state_d = ST_START;
            ST_START:  if (tick) state_d = line_s ? ST_IDLE : ST_DATA;
            ST_DATA:   if (tick && idx_q == LAST_IDX) state_d = ST_PARITY;
            ST_PARITY: if (tick) state_d = ST_GUARD;
            ST_GUARD:  if (tick) state_d = bad_q ? ST_ERRSIG : ST_IDLE;
            ST_ERRSIG: if (tick) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            shift_q <= '0;
            bad_q   <= 1'b0;
        end else begin
            if (state_q == ST_START && tick) begin
                idx_q <= '0;
            end
            if (state_q == ST_DATA && tick) begin
                shift_q <= {line_s, shift_q[DATA_W-1:1]};
                idx_q   <= idx_q + 1'b1;
            end
            if (state_q == ST_PARITY && tick) begin
                bad_q <= ^{shift_q, line_s};
            end
        end
    end

    // outputs
    always_comb begin
        tmr_load   = 1'b0;
        tmr_val    = full_m1;
        frame_done = 1'b0;
        pull_low   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!line_s) begin
                    tmr_load = 1'b1;
                    tmr_val  = half_m1;
                end
            end
            ST_START:  tmr_load = tick && !line_s;
            ST_DATA:   tmr_load = tick;
            ST_PARITY: begin
                tmr_load   = tick;
                frame_done = tick;
            end
            ST_GUARD:  tmr_load = tick && bad_q;
            ST_ERRSIG: pull_low = 1'b1;
            default:   tmr_load = 1'b0;
        endcase
    end

    assign frame_ok   = ~(^{shift_q, line_s});
    assign frame_byte = shift_q;
endmodule

// File: rtl/sc_rx_status.sv
module sc_rx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic              frame_ok,
    input  logic [DATA_W-1:0] frame_byte,
    input  logic              rd_ack,
    input  logic              perr_clr,
    input  logic              ovr_clr,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_full,
    output logic              par_err,
    output logic              overrun,
    output logic              rx_irq,
    output logic              err_irq
);
    logic still_full;
    logic good_done;
    logic bad_done;

    assign still_full = rx_full & ~rd_ack;
    assign good_done  = frame_done & frame_ok;
    assign bad_done   = frame_done & ~frame_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            rx_full <= 1'b0;
            par_err <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (frame_done && !still_full) rd_data <= frame_byte;
            rx_full <= still_full | good_done;
            par_err <= bad_done | (par_err & ~perr_clr);
            overrun <= (good_done & still_full) | (overrun & ~ovr_clr);
        end
    end

    assign rx_irq  = irq_en & rx_full;
    assign err_irq = irq_en & (par_err | overrun);
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx #(
    parameter int DIV_W       = 12,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  etu_cycles,
    input  logic              line_in,
    output logic              line_pull_low,
    input  logic              irq_en,
    input  logic              rd_ack,
    input  logic              perr_clr,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_full,
    output logic              par_err,
    output logic              overrun,
    output logic              rx_irq,
    output logic              err_irq
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line_s;
    logic                   tick;
    logic                   tmr_load;
    logic [DIV_W-1:0]       tmr_val;
    logic                   frame_done;
    logic                   frame_ok;
    logic [DATA_W-1:0]      frame_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
    end
    assign line_s = sync_q[SYNC_STAGES-1];

    sc_rx_etu_timer #(.CNT_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tick)
    );

    sc_rx_frame_fsm #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_s     (line_s),
        .etu_cycles (etu_cycles),
        .tick       (tick),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .frame_done (frame_done),
        .frame_ok   (frame_ok),
        .frame_byte (frame_byte),
        .pull_low   (line_pull_low)
    );

    sc_rx_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_ok   (frame_ok),
        .frame_byte (frame_byte),
        .rd_ack     (rd_ack),
        .perr_clr   (perr_clr),
        .ovr_clr    (ovr_clr),
        .irq_en     (irq_en),
        .rd_data    (rd_data),
        .rx_full    (rx_full),
        .par_err    (par_err),
        .overrun    (overrun),
        .rx_irq     (rx_irq),
        .err_irq    (err_irq)
    );
endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_done,
    input logic              rd_ack,
    input logic [DATA_W-1:0] rd_data,
    input logic              rx_full,
    input logic              par_err,
    input logic              overrun
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rx_full && !par_err && !overrun));

    p_full_from_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(frame_done));

    p_perr_not_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err) |-> !$rose(rx_full));

    p_ovr_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $stable(rd_data));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !frame_done) |=> !rx_full);
endmodule

bind sc_char_rx sc_char_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .rd_ack     (rd_ack),
    .rd_data    (rd_data),
    .rx_full    (rx_full),
    .par_err    (par_err),
    .overrun    (overrun)
);

// File: tb/sc_char_rx_test.sv
module sc_char_rx_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] etu_cycles = 12'd16;
    logic             drv = 1'b1;
    logic             line_in;
    logic             line_pull_low;
    logic             irq_en = 1'b0;
    logic             rd_ack = 1'b0;
    logic             perr_clr = 1'b0;
    logic             ovr_clr = 1'b0;
    logic [7:0]       rd_data;
    logic             rx_full, par_err, overrun, rx_irq, err_irq;

    int tests = 0;
    int fails = 0;
    int etu = 16;

    logic [7:0] exp_data = 8'h00;
    bit exp_full = 0, exp_perr = 0, exp_ovr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign line_in = drv & ~line_pull_low;

    sc_char_rx uut (
        .clk(clk), .rst_n(rst_n), .etu_cycles(etu_cycles),
        .line_in(line_in), .line_pull_low(line_pull_low),
        .irq_en(irq_en), .rd_ack(rd_ack), .perr_clr(perr_clr), .ovr_clr(ovr_clr),
        .rd_data(rd_data), .rx_full(rx_full), .par_err(par_err), .overrun(overrun),
        .rx_irq(rx_irq), .err_irq(err_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit model_parity(input logic [7:0] b, input bit flip);
        return (^b) ^ flip;
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " R2/R5/R6 rd_data"}, rd_data, exp_data);
        chk({tag, " R2/R3 rx_full"}, rx_full, exp_full);
        chk({tag, " R3/R7 par_err"}, par_err, exp_perr);
        chk({tag, " R6/R7 overrun"}, overrun, exp_ovr);
        chk({tag, " R8 rx_irq"}, rx_irq, irq_en & exp_full);
        chk({tag, " R8 err_irq"}, err_irq, irq_en & (exp_perr | exp_ovr));
    endtask

    // Sends one character; counts cycles with the line pulled low.
    task automatic send(input logic [7:0] b, input bit flip);
        int pulled = 0;
        bit busy = exp_full;
        drv = 1'b0; waitc(etu);
        for (int i = 0; i < 8; i++) begin
            drv = b[i];
            for (int c = 0; c < etu; c++) begin
                waitc(1);
                if (line_pull_low) pulled++;
            end
        end
        drv = model_parity(b, flip);
        for (int c = 0; c < etu; c++) begin
            waitc(1);
            if (line_pull_low) pulled++;
        end
        drv = 1'b1;
        for (int c = 0; c < 4 * etu; c++) begin
            waitc(1);
            if (line_pull_low) pulled++;
        end
        if (flip) begin
            chk("R3 error signal length", pulled, etu);
            exp_perr = 1;
            if (!busy) exp_data = b;
        end else begin
            chk("R4 no error signal on good frame", pulled, 0);
            if (busy) exp_ovr = 1;
            else begin exp_data = b; exp_full = 1; end
        end
    endtask

    task automatic pulse_ack();
        rd_ack = 1'b1; waitc(1); rd_ack = 1'b0; exp_full = 0;
    endtask

    task automatic pulse_perr_clr();
        perr_clr = 1'b1; waitc(1); perr_clr = 1'b0; exp_perr = 0;
    endtask

    task automatic pulse_ovr_clr();
        ovr_clr = 1'b1; waitc(1); ovr_clr = 1'b0; exp_ovr = 0;
    endtask

    task automatic random_run(input int n);
        for (int k = 0; k < n; k++) begin
            logic [7:0] b = 8'($urandom());
            bit flip = ($urandom() % 4) == 0;
            send(b, flip);
            check_all("R10 random");
            if ($urandom() % 3 != 0) pulse_ack();
            if ($urandom() % 2 == 0) pulse_perr_clr();
            if ($urandom() % 3 == 0) pulse_ovr_clr();
            irq_en = $urandom() % 2;
            waitc(1 + $urandom() % 7);
            check_all("R7/R8 after software");
        end
    endtask

    initial begin
        void'($urandom(32'h5C7A_0011));
        waitc(3);
        check_all("R1 reset");
        chk("R1 pull low in reset", line_pull_low, 0);
        rst_n = 1'b1;
        waitc(3);
        irq_en = 1'b1;
        check_all("R1 after release");

        // directed: good frame, LSB first
        send(8'hA5, 0);
        check_all("R2 good frame");
        // good frame while full -> overrun, data kept
        send(8'h3C, 0);
        check_all("R6 overrun");
        // bad frame while full -> data kept, no full change
        send(8'hFF, 1);
        check_all("R5 bad frame over full data");
        pulse_ack(); pulse_perr_clr(); pulse_ovr_clr();
        waitc(2);
        check_all("R7 clears");
        // bad frame while empty -> byte written, full stays 0
        send(8'h81, 1);
        check_all("R5 bad frame written");
        pulse_perr_clr();
        // start glitch shorter than half ETU
        drv = 1'b0; waitc(3); drv = 1'b1;
        begin
            int pl = 0;
            for (int c = 0; c < 14 * etu; c++) begin
                waitc(1);
                if (line_pull_low) pl++;
            end
            chk("R9 glitch no error signal", pl, 0);
        end
        check_all("R9 glitch ignored");
        send(8'h00, 0);
        check_all("R9 frame after glitch");
        pulse_ack();

        random_run(30);

        // change ETU between frames
        etu = 11; etu_cycles = 12'd11;
        waitc(5);
        send(8'h5A, 0);
        check_all("R10 short ETU");
        pulse_ack();
        random_run(30);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule